// File: doc/BRIEF.md
# QoS-Priority SRAM Port Arbiter

This block shares one single-ported SRAM among several masters. In every cycle it looks at all pending requests and picks one winner. The master with the highest quality-of-service level wins. If several masters share that level, the one with the lowest port index wins. The winner's address, write data and write enable are driven onto the SRAM port in the same cycle. That master sees a one-cycle grant.

Each master carries a 2-bit QoS level. Levels 0 and 1 tolerate latency, so a request at either level must be held for one cycle before it may compete. Levels 2 and 3 compete as soon as they are raised. The QoS level of each port sits in a small register that a shared write strobe can reload. Ports marked as fixed are tied to level 3 and ignore writes. Read data comes back one cycle after the grant, together with the index of the port it belongs to.

Top module: `qos_sram_arb`

## Requirements
- R1: QoS is a 2-bit level: 0 = off, 1 = low, 2 = medium, 3 = high, and a larger value means higher priority. After reset, port 0 is at 3, port 1 at 2, port 2 at 2, and port 3 is fixed at 3 (parameter defaults).
- R2: Among the eligible requests, the grant goes to one with the highest QoS level. Whenever at least one request is eligible, some port is granted.
- R3: When several eligible requests share the highest level, the lowest port index is granted.
- R4: A request at level 0 or 1 is eligible only in a cycle after one in which the same port requested and was not granted. Such a request is never granted in the first cycle it is raised.
- R5: A held low-level request loses its first eligible cycle when a higher-priority eligible request is present. It stays eligible while it is held, and it is granted once it is the best eligible request.
- R6: A fixed port always arbitrates at level 3. Writes to its QoS setting are ignored.
- R7: When cfg_we_i[p] is high at a clock edge, port p takes the level on cfg_qos_i from the next cycle on. The arbitration in the writing cycle still uses the old level.
- R8: At most one gnt_o bit is high in a cycle, and only for a requesting port. mem_req_o is high exactly when a grant is given, and mem_addr_o, mem_we_o and mem_wdata_o carry the granted port's inputs.
- R9: One cycle after a read grant, rvalid_o is high, rid_o holds the granted port's index and rdata_o holds the SRAM word. A write grant gives no rvalid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | NPorts | Per-port QoS write strobe |
| cfg_qos_i | input | 2 | QoS value written by cfg_we_i |
| req_i | input | NPorts | Access request per port |
| we_i | input | NPorts | Write enable per port |
| addr_i | input | NPorts*AddrW | Address per port, port p at bits [p*AddrW +: AddrW] |
| wdata_i | input | NPorts*DataW | Write data per port |
| gnt_o | output | NPorts | One-cycle grant per port |
| rvalid_o | output | 1 | Read data valid |
| rid_o | output | IdxW | Port index of the returned read data |
| rdata_o | output | DataW | Returned read data |
| mem_req_o | output | 1 | SRAM access strobe |
| mem_we_o | output | 1 | SRAM write enable |
| mem_addr_o | output | AddrW | SRAM address |
| mem_wdata_o | output | DataW | SRAM write data |
| mem_rdata_i | input | DataW | SRAM read data, one cycle after the access |

## Verification
Directed sequences cover the following cases:
- A medium-level port against a high-level port, which shows that level ordering is applied.
- Two ports at equal level, which shows the index tie-break.
- A single low-level request, which shows the forced wait.
- A low-level request held against a later medium-level one, which shows that eligibility is kept across a lost cycle.
- A write to a fixed port and a write that coincides with a request, which separate ignored writes from delayed ones.

A long random run then mixes requests, read and write directions, addresses and level changes. This exposes any mismatch in grant choice, wait bookkeeping, SRAM steering or read return tagging against a bench model of the arbiter and the memory.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  typedef enum logic [1:0] {
    QOS_OFF  = 2'd0,
    QOS_LOW  = 2'd1,
    QOS_MED  = 2'd2,
    QOS_HIGH = 2'd3
  } qos_e;

  function automatic logic needs_wait(logic [1:0] q);
    return q < QOS_MED;
  endfunction
endpackage

// File: rtl/qos_arb_cfg.sv
module qos_arb_cfg
  import qos_arb_pkg::*;
#(
  parameter int unsigned NPorts = 4,
  parameter logic [2*NPorts-1:0] QosRst = '1,
  parameter logic [NPorts-1:0] Fixed = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPorts-1:0]   we_i,
  input  logic [1:0]          qos_i,
  output logic [2*NPorts-1:0] qos_o
);
  for (genvar p = 0; p < NPorts; p++) begin : g_port
    if (Fixed[p]) begin : g_fixed
      assign qos_o[2*p +: 2] = QOS_HIGH;
    end else begin : g_prog
      logic [1:0] qos_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     qos_q <= QosRst[2*p +: 2];
        else if (we_i[p]) qos_q <= qos_i;
      end
      assign qos_o[2*p +: 2] = qos_q;

      assert_cfg_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i[p] |=> qos_o[2*p +: 2] == $past(qos_i));
    end
  end
endmodule

// File: rtl/qos_arb_elig.sv
module qos_arb_elig
  import qos_arb_pkg::*;
#(
  parameter int unsigned NPorts = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPorts-1:0]   req_i,
  input  logic [NPorts-1:0]   gnt_i,
  input  logic [2*NPorts-1:0] qos_i,
  output logic [NPorts-1:0]   elig_o
);
  logic [NPorts-1:0] waited_q;

  // a request that was pending and lost last cycle has served its wait
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) waited_q <= '0;
    else         waited_q <= req_i & ~gnt_i;
  end

  for (genvar p = 0; p < NPorts; p++) begin : g_elig
    assign elig_o[p] = req_i[p] & (~needs_wait(qos_i[2*p +: 2]) | waited_q[p]);

    assert_low_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elig_o[p] && needs_wait(qos_i[2*p +: 2])) |-> $past(req_i[p] && !gnt_i[p]));
  end
endmodule

// File: rtl/qos_arb_pick.sv
module qos_arb_pick #(
  parameter int unsigned NPorts = 4,
  localparam int unsigned IdxW = (NPorts > 1) ? $clog2(NPorts) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPorts-1:0]   req_i,
  input  logic [NPorts-1:0]   elig_i,
  input  logic [2*NPorts-1:0] qos_i,
  output logic [NPorts-1:0]   gnt_o,
  output logic [IdxW-1:0]     idx_o,
  output logic                any_o
);
  logic [1:0] best_q;

  // strict compare keeps the lowest index on equal level
  always_comb begin
    best_q = '0;
    idx_o  = '0;
    any_o  = 1'b0;
    for (int p = 0; p < NPorts; p++) begin
      if (elig_i[p] && (!any_o || qos_i[2*p +: 2] > best_q)) begin
        any_o  = 1'b1;
        best_q = qos_i[2*p +: 2];
        idx_o  = IdxW'(p);
      end
    end
    gnt_o = any_o ? (NPorts'(1) << idx_o) : '0;
  end

  assert_one_gnt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_gnt_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  assert_work_conserve_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|elig_i) |-> (|gnt_o));
endmodule

// File: rtl/qos_sram_arb.sv
module qos_sram_arb #(
  parameter int unsigned NPorts = 4,
  parameter int unsigned AddrW  = 8,
  parameter int unsigned DataW  = 32,
  parameter logic [2*NPorts-1:0] QosRst = 8'b11_10_10_11,
  parameter logic [NPorts-1:0] Fixed = 4'b1000,
  localparam int unsigned IdxW = (NPorts > 1) ? $clog2(NPorts) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NPorts-1:0]         cfg_we_i,
  input  logic [1:0]                cfg_qos_i,
  input  logic [NPorts-1:0]         req_i,
  input  logic [NPorts-1:0]         we_i,
  input  logic [NPorts*AddrW-1:0]   addr_i,
  input  logic [NPorts*DataW-1:0]   wdata_i,
  output logic [NPorts-1:0]         gnt_o,
  output logic                      rvalid_o,
  output logic [IdxW-1:0]           rid_o,
  output logic [DataW-1:0]          rdata_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [AddrW-1:0]          mem_addr_o,
  output logic [DataW-1:0]          mem_wdata_o,
  input  logic [DataW-1:0]          mem_rdata_i
);
  logic [2*NPorts-1:0] qos;
  logic [NPorts-1:0]   elig;
  logic [IdxW-1:0]     idx;
  logic                any;

  qos_arb_cfg #(.NPorts(NPorts), .QosRst(QosRst), .Fixed(Fixed)) i_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .qos_i(cfg_qos_i), .qos_o(qos)
  );

  qos_arb_elig #(.NPorts(NPorts)) i_elig (
    .clk_i, .rst_ni, .req_i, .gnt_i(gnt_o), .qos_i(qos), .elig_o(elig)
  );

  qos_arb_pick #(.NPorts(NPorts)) i_pick (
    .clk_i, .rst_ni, .req_i, .elig_i(elig), .qos_i(qos),
    .gnt_o, .idx_o(idx), .any_o(any)
  );

  assign mem_req_o   = any;
  assign mem_we_o    = any & we_i[idx];
  assign mem_addr_o  = addr_i[idx*AddrW +: AddrW];
  assign mem_wdata_o = wdata_i[idx*DataW +: DataW];

  logic            rvalid_q;
  logic [IdxW-1:0] rid_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rid_q    <= '0;
    end else begin
      rvalid_q <= any & ~we_i[idx];
      if (any) rid_q <= idx;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rid_o    = rid_q;
  assign rdata_o  = mem_rdata_i;

  assert_rvalid_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(mem_req_o && !mem_we_o));
  assert_rid_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(gnt_o) == (NPorts'(1) << rid_o));
  assert_mem_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o == (|gnt_o));
endmodule

// File: tb/test_qos_sram_arb.sv
module test_qos_sram_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int IW = 2;
  localparam logic [N-1:0] FIXED = 4'b1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cfg_we = '0;
  logic [1:0] cfg_qos = '0;
  logic [N-1:0] req = '0, we = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*DW-1:0] wdata = '0;
  logic [N-1:0] gnt;
  logic rvalid;
  logic [IW-1:0] rid;
  logic [DW-1:0] rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int checks = 0, errors = 0;

  qos_sram_arb i_qos_sram_arb (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_qos_i(cfg_qos),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .gnt_o(gnt), .rvalid_o(rvalid), .rid_o(rid), .rdata_o(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] init_word(int a);
    return 32'hA5000000 ^ (a * 32'h00010203);
  endfunction

  // SRAM model: registered read
  logic [DW-1:0] sram [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) sram[i] <= init_word(i);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) sram[mem_addr] <= mem_wdata;
      mem_rdata <= sram[mem_addr];
    end
  end

  // bench reference state
  int m_qos [N];
  bit m_wait [N];
  logic [DW-1:0] m_mem [256];
  bit exp_rv;
  int exp_rid;
  logic [DW-1:0] exp_rdata;

  function automatic int exp_pick(logic [N-1:0] r);
    int best = -1;
    for (int p = 0; p < N; p++) begin
      bit el = r[p] && (m_qos[p] >= 2 || m_wait[p]);
      if (el && (best < 0 || m_qos[p] > m_qos[best])) best = p;
    end
    return best;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(logic [N-1:0] r, logic [N-1:0] w, logic [N*AW-1:0] a,
                       logic [N*DW-1:0] d, logic [N-1:0] cw, logic [1:0] cq, string tag);
    int win;
    logic [N-1:0] eg;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; cfg_we = cw; cfg_qos = cq;
    #1;
    win = exp_pick(r);
    eg = (win < 0) ? '0 : (N'(1) << win);
    chk(gnt == eg, tag, "gnt", gnt, eg);
    chk(mem_req == (win >= 0), "R8", "mem_req", mem_req, win >= 0);
    if (win >= 0) begin
      chk(mem_addr == a[win*AW +: AW] && mem_we == w[win], "R8", "mem addr/we",
          {mem_we, mem_addr}, {w[win], a[win*AW +: AW]});
      if (w[win]) chk(mem_wdata == d[win*DW +: DW], "R8", "mem_wdata", mem_wdata, d[win*DW +: DW]);
    end
    chk(rvalid == exp_rv, "R9", "rvalid", rvalid, exp_rv);
    if (exp_rv) begin
      chk(rid == IW'(exp_rid), "R9", "rid", rid, exp_rid);
      chk(rdata == exp_rdata, "R9", "rdata", rdata, exp_rdata);
    end
    @(posedge clk);
    exp_rv = (win >= 0) && !w[win];
    if (win >= 0) begin
      exp_rid = win;
      exp_rdata = m_mem[a[win*AW +: AW]];
      if (w[win]) m_mem[a[win*AW +: AW]] = d[win*DW +: DW];
    end
    for (int p = 0; p < N; p++) begin
      m_wait[p] = r[p] && !eg[p];
      if (cw[p] && !FIXED[p]) m_qos[p] = cq;
    end
  endtask

  task automatic idle();
    cycle('0, '0, '0, '0, '0, 2'd0, "idle");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N*AW-1:0] ra;
    logic [N*DW-1:0] rd;
    m_qos[0] = 3; m_qos[1] = 2; m_qos[2] = 2; m_qos[3] = 3;
    for (int p = 0; p < N; p++) m_wait[p] = 0;
    for (int i = 0; i < 256; i++) m_mem[i] = init_word(i);
    exp_rv = 0; exp_rid = 0; exp_rdata = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(gnt == '0 && rvalid == 1'b0, "R9", "reset outputs", {gnt, rvalid}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset levels, port 0 (3) beats port 1 (2)
    cycle(4'b0011, '0, {8'd0, 8'd0, 8'd5, 8'd4}, '0, '0, 2'd0, "R1");
    idle();
    // R1: port 2 at level 2 granted without wait
    cycle(4'b0100, '0, {8'd0, 8'd9, 8'd0, 8'd0}, '0, '0, 2'd0, "R1");
    idle();
    // R3: port 0 and fixed port 3 both at 3 -> port 0
    cycle(4'b1001, '0, '0, '0, '0, 2'd0, "R3");
    idle();
    // R2: raise port 2 to 3; it beats port 1 at 2
    cycle('0, '0, '0, '0, 4'b0100, 2'd3, "R7");
    cycle(4'b0110, '0, '0, '0, '0, 2'd0, "R2");
    idle();
    // R4: port 0 to level 1; single request waits one cycle
    cycle('0, '0, '0, '0, 4'b0001, 2'd1, "R7");
    cycle(4'b0001, '0, {24'd0, 8'd20}, '0, '0, 2'd0, "R4");
    cycle(4'b0001, '0, {24'd0, 8'd20}, '0, '0, 2'd0, "R4");
    idle();
    // R5: held low request loses to level-2 port 1, then wins
    cycle(4'b0001, '0, '0, '0, '0, 2'd0, "R5");
    cycle(4'b0011, '0, '0, '0, '0, 2'd0, "R5");
    cycle(4'b0001, '0, '0, '0, '0, 2'd0, "R5");
    idle();
    // R6: write to fixed port 3 ignored, still immediate at level 3
    cycle('0, '0, '0, '0, 4'b1000, 2'd0, "R6");
    cycle(4'b1000, '0, {8'd33, 24'd0}, '0, '0, 2'd0, "R6");
    idle();
    // R7: write coinciding with request uses old level
    cycle(4'b0010, '0, '0, '0, 4'b0010, 2'd1, "R7");
    cycle(4'b0010, '0, '0, '0, '0, 2'd0, "R7");
    cycle(4'b0010, '0, '0, '0, '0, 2'd0, "R7");
    idle();
    // R9: write then read of same word from port 3
    cycle(4'b1000, 4'b1000, {8'd77, 24'd0}, {32'hDEADBEEF, 96'd0}, '0, 2'd0, "R9");
    cycle(4'b1000, '0, {8'd77, 24'd0}, '0, '0, 2'd0, "R9");
    idle();

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] cw;
      for (int p = 0; p < N; p++) begin
        ra[p*AW +: AW] = AW'($urandom);
        rd[p*DW +: DW] = $urandom;
      end
      cw = ($urandom % 16 == 0) ? N'($urandom) : '0;
      cycle(N'($urandom), N'($urandom), ra, rd, cw, 2'($urandom), "R2,R3,R4,R5");
    end
    idle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule